// File: doc/BRIEF.md
# Link Speed Change Sequencer

This block is the control state machine that moves a PCIe-style PHY from one signalling rate to another. The MAC drives a 2-bit rate code. When that code moves to a legal rate different from the one in use, the sequencer runs a fixed order of steps. It holds the PCS in reset and gates its clocks. It then points the clock and datapath multiplexers at the target rate and requests the rate change from the PMA. After every lane reports done, it brings the clocks back, releases the reset and gives a one-cycle PHY-status pulse. The datapath stays 32 bits wide at every rate. At the two lower rates the legacy PCS carries the traffic. At the top rate the 128b/130b PCS carries it, so the datapath select flips only when a change enters or leaves that rate.

In a bonded group of 2, 4 or 8 lanes, lane 0 acts as master. Its sequencer drives reset, clock enable and the PMA request for every lane, and it moves on only when all lanes have reported done. A single lane controls itself. If the PMA has not answered within a parameterised number of cycles, the sequencer raises an error pulse, restores the multiplexer setting of the rate still in force and returns to idle. All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `rate_change_seq`

## Requirements
- R1: After reset: `pcs_rst` all 0, `pcs_clk_en` all 1, `pma_req` all 0, `pma_rate`=00, `link_rate`=00, `sel_gen3`=0, `phystatus`=0, `tmo_err`=0.
- R2: Rate codes are 00 = 2.5 Gb/s, 01 = 5 Gb/s, 10 = 8 Gb/s and 11 = reserved. While idle, if `rate_req` differs from its value in the previous cycle, is not 11 and differs from `link_rate`, the next cycle shows `pcs_rst` high on all lanes with clocks still enabled.
- R3: One cycle after reset is applied, `pcs_clk_en` drops to 0 on all lanes. The clocks stay gated only while reset is held.
- R4: One cycle after gating, `pma_rate` takes the target code and `sel_gen3` becomes 1 exactly when the target is 10. Apart from a timeout restore, these change only while the clocks are gated.
- R5: The cycle after that, `pma_req` goes high on all lanes and stays high until a clock edge sees every bit of `pma_done` high. If only some lanes report done, the sequencer does not advance.
- R6: After full done, the sequencer gives one cycle with clocks enabled and reset held, then one cycle with reset released, then the `phystatus` cycle. `link_rate` shows the target from that cycle onward.
- R7: `phystatus` is high for exactly one cycle per completed change.
- R8: A request of 11, a request equal to `link_rate`, and any change of `rate_req` while a sequence is running have no effect: reset, clocks and `link_rate` are untouched.
- R9: If full done is not seen in `TMO_CYCLES` cycles of request, `pma_req` drops, `tmo_err` pulses for one cycle, `pma_rate`/`sel_gen3` return to the `link_rate` setting, reset is released, clocks run and no `phystatus` follows.
- R10: After a timeout, no new sequence starts until `rate_req` changes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_req | input | 2 | Rate code from the MAC |
| pma_done | input | LANES | Per-lane rate-change done from the PMA |
| pcs_rst | output | LANES | Per-lane PCS reset |
| pcs_clk_en | output | LANES | Per-lane PCS clock enable |
| pma_req | output | LANES | Per-lane rate-change request to the PMA |
| pma_rate | output | 2 | Rate code applied to PMA and clock multiplexers |
| sel_gen3 | output | 1 | 1 selects the 128b/130b PCS datapath |
| link_rate | output | 2 | Rate confirmed by the last completed change |
| phystatus | output | 1 | One-cycle completion pulse |
| tmo_err | output | 1 | One-cycle PMA timeout pulse |

## Verification
The bench runs changes between the two legacy rates and into and out of the top rate. These show whether the datapath select follows only transitions that touch the 128b/130b PCS. It varies the PMA answer delay and returns done on only some lanes. A sequencer that advances on the master lane alone then differs from one that waits for the whole group. Requests of the reserved code, requests equal to the current rate and changes made mid-sequence are each applied, to confirm that none of them is acted upon. A silent PMA exercises the timeout, the restore and the rule that a held code does not start a retry.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RST, ST_GATE, ST_MUX, ST_REQ, ST_ENA, ST_REL, ST_STAT, ST_FAIL
  } seq_state_t;

  localparam logic [1:0] RATE_G3  = 2'b10;
  localparam logic [1:0] RATE_RSV = 2'b11;
endpackage

// File: rtl/rcs_timer.sv
module rcs_timer #(
  parameter int TMO_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(TMO_CYCLES - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/rcs_fanout.sv
module rcs_fanout #(
  parameter int LANES = 4
) (
  input  logic             rst_i,
  input  logic             clken_i,
  input  logic             req_i,
  input  logic [LANES-1:0] done_i,
  output logic [LANES-1:0] rst_o,
  output logic [LANES-1:0] clken_o,
  output logic [LANES-1:0] req_o,
  output logic             all_done_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rst_o[i]   = rst_i;
    assign clken_o[i] = clken_i;
    assign req_o[i]   = req_i;
  end

  if (LANES == 1) begin : g_single
    assign all_done_o = done_i[0];
  end else begin : g_bonded
    assign all_done_o = &done_i;
  end
endmodule

// File: rtl/rate_change_seq.sv
module rate_change_seq
  import rcs_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int TMO_CYCLES = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rate_req,
  input  logic [LANES-1:0] pma_done,
  output logic [LANES-1:0] pcs_rst,
  output logic [LANES-1:0] pcs_clk_en,
  output logic [LANES-1:0] pma_req,
  output logic [1:0]       pma_rate,
  output logic             sel_gen3,
  output logic [1:0]       link_rate,
  output logic             phystatus,
  output logic             tmo_err
);
  seq_state_t st, st_nx;
  logic [1:0] rate_q, tgt_q, prate_q, link_q;
  logic       sel_q, start, all_done, expired;
  logic       rst_all, gate_all, req_all;

  assign start = (st == ST_IDLE) && (rate_req != rate_q) &&
                 (rate_req != RATE_RSV) && (rate_req != link_q);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (start) st_nx = ST_RST;
      ST_RST:  st_nx = ST_GATE;
      ST_GATE: st_nx = ST_MUX;
      ST_MUX:  st_nx = ST_REQ;
      ST_REQ:  if (all_done) st_nx = ST_ENA;
               else if (expired) st_nx = ST_FAIL;
      ST_ENA:  st_nx = ST_REL;
      ST_REL:  st_nx = ST_STAT;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rate_q  <= 2'b00;
      tgt_q   <= 2'b00;
      prate_q <= 2'b00;
      link_q  <= 2'b00;
      sel_q   <= 1'b0;
    end else begin
      st     <= st_nx;
      rate_q <= rate_req;
      if (start) tgt_q <= rate_req;
      if (st == ST_GATE) begin
        prate_q <= tgt_q;
        sel_q   <= (tgt_q == RATE_G3);
      end
      if (st_nx == ST_FAIL) begin
        prate_q <= link_q;
        sel_q   <= (link_q == RATE_G3);
      end
      if (st == ST_REL) link_q <= tgt_q;
    end
  end

  assign rst_all  = st inside {ST_RST, ST_GATE, ST_MUX, ST_REQ, ST_ENA};
  assign gate_all = st inside {ST_GATE, ST_MUX, ST_REQ};
  assign req_all  = (st == ST_REQ);

  rcs_fanout #(.LANES(LANES)) u_fan (
    .rst_i      (rst_all),
    .clken_i    (!gate_all),
    .req_i      (req_all),
    .done_i     (pma_done),
    .rst_o      (pcs_rst),
    .clken_o    (pcs_clk_en),
    .req_o      (pma_req),
    .all_done_o (all_done)
  );

  rcs_timer #(.TMO_CYCLES(TMO_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (req_all),
    .expired (expired)
  );

  assign pma_rate  = prate_q;
  assign sel_gen3  = sel_q;
  assign link_rate = link_q;
  assign phystatus = (st == ST_STAT);
  assign tmo_err   = (st == ST_FAIL);

  p_gate_in_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pcs_clk_en[0] |-> pcs_rst[0]);
  p_req_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pma_req[0] |-> (pcs_rst[0] && !pcs_clk_en[0]));
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pma_req[0] && !all_done && !expired) |=> pma_req[0]);
  p_rate_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pma_rate != RATE_RSV);
  p_sel_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_gen3) |-> (!pcs_clk_en[0] || tmo_err));
  p_link_at_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(link_rate) |-> phystatus);
  p_status_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phystatus |-> (!pcs_rst[0] && pcs_clk_en[0]));
  p_status_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phystatus |=> !phystatus);
  p_tmo_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |=> (!tmo_err && !phystatus));
endmodule

// File: tb/tb_rate_change_seq.sv
module tb_rate_change_seq;
  localparam int LN  = 4;
  localparam int TMO = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [1:0]    rate_req;
  logic [LN-1:0] pma_done;
  logic [LN-1:0] pcs_rst, pcs_clk_en, pma_req;
  logic [1:0]    pma_rate, link_rate;
  logic          sel_gen3, phystatus, tmo_err;

  rate_change_seq #(.LANES(LN), .TMO_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .rate_req(rate_req), .pma_done(pma_done),
    .pcs_rst(pcs_rst), .pcs_clk_en(pcs_clk_en), .pma_req(pma_req),
    .pma_rate(pma_rate), .sel_gen3(sel_gen3), .link_rate(link_rate),
    .phystatus(phystatus), .tmo_err(tmo_err)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: phase of the change procedure as timed in the requirements
  // 0 idle, 1 reset, 2 gated, 3 mux set, 4 request, 5 clocks on, 6 released, 7 status, 8 timeout
  int         ph = 0, n = 0;
  logic [1:0] prev = 2'b00, tgt = 2'b00, m_link = 2'b00, m_prate = 2'b00;
  logic       m_sel = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; n = 0; prev = 2'b00; tgt = 2'b00;
      m_link = 2'b00; m_prate = 2'b00; m_sel = 1'b0;
    end else begin
      case (ph)
        0: if (rate_req != prev && rate_req != 2'b11 && rate_req != m_link) begin
             ph = 1; tgt = rate_req;
           end
        1: ph = 2;
        2: begin ph = 3; m_prate = tgt; m_sel = (tgt == 2'b10); end
        3: begin ph = 4; n = 0; end
        4: if (&pma_done) ph = 5;
           else if (n == TMO - 1) begin
             ph = 8; m_prate = m_link; m_sel = (m_link == 2'b10);
           end else n++;
        5: ph = 6;
        6: begin ph = 7; m_link = tgt; end
        default: ph = 0;
      endcase
      prev = rate_req;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(pcs_rst == {LN{ph >= 1 && ph <= 5}}, "R2 pcs_rst", pcs_rst, {LN{ph >= 1 && ph <= 5}});
      chk(pcs_clk_en == {LN{!(ph >= 2 && ph <= 4)}}, "R3 pcs_clk_en", pcs_clk_en,
          {LN{!(ph >= 2 && ph <= 4)}});
      chk(pma_rate == m_prate && sel_gen3 == m_sel, "R4 pma_rate/sel_gen3",
          {pma_rate, sel_gen3}, {m_prate, m_sel});
      chk(pma_req == {LN{ph == 4}}, "R5 pma_req", pma_req, {LN{ph == 4}});
      chk(link_rate == m_link, "R6 link_rate", link_rate, m_link);
      chk(phystatus == (ph == 7), "R7 phystatus", phystatus, ph == 7);
      chk(tmo_err == (ph == 8), "R9 tmo_err", tmo_err, ph == 8);
    end
  end

  // PMA responder: answers after resp_dly cycles of request on the lanes in resp_mask
  int         resp_dly = 2, rcnt = 0;
  logic [LN-1:0] resp_mask = '1;
  always @(negedge clk) begin
    if (pma_req[0]) begin
      rcnt++;
      pma_done = (rcnt >= resp_dly) ? resp_mask : '0;
    end else begin
      rcnt = 0;
      pma_done = '0;
    end
  end

  task automatic set_rate(input logic [1:0] v);
    @(negedge clk);
    rate_req = v;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    for (int k = 0; k < 200 && ph != 0; k++) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0; rate_req = 2'b00; pma_done = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pcs_rst == '0 && pcs_clk_en == '1 && pma_req == '0, "R1 lanes",
        {pcs_rst, pcs_clk_en, pma_req}, {4'h0, 4'hF, 4'h0});
    chk(pma_rate == 2'b00 && link_rate == 2'b00 && !sel_gen3 && !phystatus && !tmo_err,
        "R1 status", {pma_rate, link_rate, sel_gen3, phystatus, tmo_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 legacy to legacy: 2.5 -> 5
    resp_dly = 3; set_rate(2'b01); wait_idle();
    chk(link_rate == 2'b01 && !sel_gen3, "R6 to 5G", {link_rate, sel_gen3}, {2'b01, 1'b0});
    // R4 into top rate
    resp_dly = 1; set_rate(2'b10); wait_idle();
    chk(link_rate == 2'b10 && sel_gen3, "R4 to 8G", {link_rate, sel_gen3}, {2'b10, 1'b1});
    // out of top rate
    resp_dly = 5; set_rate(2'b00); wait_idle();
    chk(link_rate == 2'b00 && !sel_gen3, "R4 to 2.5G", {link_rate, sel_gen3}, {2'b00, 1'b0});

    // R8 reserved code and same-rate request ignored
    set_rate(2'b11); repeat (6) @(negedge clk);
    chk(pcs_rst == '0 && link_rate == 2'b00, "R8 reserved", {pcs_rst, link_rate}, 0);
    set_rate(2'b00); repeat (6) @(negedge clk);
    chk(pcs_rst == '0 && link_rate == 2'b00, "R8 same rate", {pcs_rst, link_rate}, 0);

    // R5 partial done holds the request
    resp_dly = 1; resp_mask = 4'b0111; set_rate(2'b10);
    repeat (9) @(negedge clk);
    chk(pma_req == '1 && !phystatus, "R5 partial done", pma_req, 4'hF);
    resp_mask = '1; wait_idle();
    chk(link_rate == 2'b10, "R5 full done", link_rate, 2'b10);

    // R8 change while busy is ignored
    resp_dly = 4; set_rate(2'b01);
    repeat (4) @(negedge clk);
    rate_req = 2'b00; wait_idle();
    repeat (4) @(negedge clk);
    chk(link_rate == 2'b01 && pcs_rst == '0, "R8 busy change", link_rate, 2'b01);

    // R9 timeout with no PMA answer
    resp_mask = '0; set_rate(2'b10); wait_idle();
    chk(link_rate == 2'b01 && pma_rate == 2'b01 && !sel_gen3, "R9 restore",
        {link_rate, pma_rate, sel_gen3}, {2'b01, 2'b01, 1'b0});
    // R10 held code does not retry
    repeat (10) @(negedge clk);
    chk(pcs_rst == '0 && pma_req == '0, "R10 no retry", {pcs_rst, pma_req}, 0);
    resp_mask = '1; resp_dly = 2; set_rate(2'b00); wait_idle();
    chk(link_rate == 2'b00, "R10 new change", link_rate, 2'b00);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule